// File: doc/BRIEF.md
# Native display mode selector

This block takes a short run of decoded detailed-timing descriptors for one attached display and picks the native mode among them. The descriptors arrive one per cycle-strobe as separate fields: pixel clock, active, blanking, sync offset and sync width for both axes, a two-bit sync type, two misc polarity bits and an interlace bit. A frame of descriptors is opened by a start strobe and closed by an end strobe.

The widest active mode in the frame wins. From it the block derives sync start, sync end and total for each axis, scales the pixel clock to kilohertz, and sets the polarity and interlace flags. On the end strobe it latches the result. If the chosen mode is smaller than VGA, or no mode was taken, the result is marked invalid. A digital-input indication is forwarded with a valid result.

Top module: `native_mode_sel`

## Requirements
- R1: After reset `valid_o`, `digital_o`, all flag outputs and all timing outputs are 0.
- R2: A descriptor with `pclk_i` equal to 0 is never selected, whatever its active sizes.
- R3: A descriptor replaces the held choice only when its `h_active_i` is strictly greater than the held horizontal active size. A later descriptor of equal width and different height does not replace it.
- R4: For each axis, sync start = active + sync offset, sync end = sync start + sync width, and total = active + blanking. Sums are widened by 2 bits so they never wrap.
- R5: `pixel_clock_o` equals the selected `pclk_i` times 10.
- R6: `hsync_pos_o` = misc bit 0 and `vsync_pos_o` = misc bit 1 only when `sync_type_i` is 3. Otherwise both are 0. `interlace_o` copies the selected `interlace_i`.
- R7: The result is invalid when the held horizontal active size is below `MIN_H` (640) or the vertical is below `MIN_V` (480); an empty frame counts as size 0. An invalid result drives every timing and flag output to 0.
- R8: `digital_o` equals the `digital_i` sampled on the end strobe when the result is valid, and is 0 when it is invalid.
- R9: `frame_start_i` clears the held choice, so a frame's result depends only on its own descriptors. A descriptor in the same cycle counts as the first of the new frame.
- R10: Outputs change only on the clock edge that samples `frame_end_i` high; that edge's result reflects descriptors accepted on earlier edges. Between end strobes the outputs hold.
- R11: Only the first `MAX_DESC` (4) descriptor strobes of a frame are considered. Strobes with a zero pixel clock count toward the limit, and later strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Opens a new descriptor frame |
| frame_end_i | input | 1 | Closes the frame and latches the result |
| desc_valid_i | input | 1 | Descriptor fields are present this cycle |
| pclk_i | input | 16 | Pixel clock in 10 kHz units |
| h_active_i | input | 12 | Horizontal active pixels |
| h_blank_i | input | 12 | Horizontal blanking |
| h_sync_off_i | input | 12 | Horizontal sync offset |
| h_sync_width_i | input | 12 | Horizontal sync width |
| v_active_i | input | 12 | Vertical active lines |
| v_blank_i | input | 12 | Vertical blanking |
| v_sync_off_i | input | 12 | Vertical sync offset |
| v_sync_width_i | input | 12 | Vertical sync width |
| sync_type_i | input | 2 | Sync type code; 3 enables polarity bits |
| misc_i | input | 2 | Bit 0 horizontal, bit 1 vertical positive polarity |
| interlace_i | input | 1 | Interlaced mode |
| digital_i | input | 1 | Display has a digital input |
| valid_o | output | 1 | Latched result is usable |
| pixel_clock_o | output | 20 | Pixel clock in kHz |
| h_active_o | output | 12 | Horizontal active |
| h_sync_start_o | output | 14 | Horizontal sync start |
| h_sync_end_o | output | 14 | Horizontal sync end |
| h_total_o | output | 14 | Horizontal total |
| v_active_o | output | 12 | Vertical active |
| v_sync_start_o | output | 14 | Vertical sync start |
| v_sync_end_o | output | 14 | Vertical sync end |
| v_total_o | output | 14 | Vertical total |
| hsync_pos_o | output | 1 | Positive horizontal sync |
| vsync_pos_o | output | 1 | Positive vertical sync |
| interlace_o | output | 1 | Interlaced result |
| digital_o | output | 1 | Digital display indication |

## Verification
Frames mix widths in rising, falling and equal order, so that a greater-or-equal test or a vertical compare gives a different winner from the strictly-wider rule. Zero-clock descriptors carry the largest width in the frame, which shows whether the zero-clock rule is applied. The size checks cover 600x480, 640x479 and exactly 640x480, which places the VGA floor at its edges. Further frames test an empty frame after a valid one, a fifth descriptor that would otherwise win, and sync types 2 and 3 with the same misc bits, which separates the frame-reset, count-limit and polarity-gating rules.

// File: rtl/nms_pkg.sv
package nms_pkg;
  parameter int unsigned FW  = 12;      // active/blank/offset/width field
  parameter int unsigned PW  = 16;      // pixel clock field
  localparam int unsigned SW  = FW + 2; // derived sums, no wrap
  localparam int unsigned PCW = PW + 4; // pclk * 10

  localparam logic [1:0] SYNC_POL_VALID = 2'd3;

  typedef struct packed {
    logic [PW-1:0] pclk;
    logic [FW-1:0] h_act, h_blank, h_off, h_wid;
    logic [FW-1:0] v_act, v_blank, v_off, v_wid;
    logic [1:0]    sync_type;
    logic [1:0]    misc;
    logic          interlace;
  } desc_t;

  typedef struct packed {
    logic [PCW-1:0] pclk_x10;
    logic [FW-1:0]  h_act;
    logic [SW-1:0]  h_ss, h_se, h_tot;
    logic [FW-1:0]  v_act;
    logic [SW-1:0]  v_ss, v_se, v_tot;
    logic           hpos, vpos, il;
  } mode_t;
endpackage

// File: rtl/nms_axis_derive.sv
module nms_axis_derive #(
  parameter int unsigned FW = 12,
  parameter int unsigned SW = FW + 2
) (
  input  logic [FW-1:0] act_i,
  input  logic [FW-1:0] blank_i,
  input  logic [FW-1:0] off_i,
  input  logic [FW-1:0] wid_i,
  output logic [SW-1:0] ss_o,
  output logic [SW-1:0] se_o,
  output logic [SW-1:0] tot_o
);
  always_comb begin
    ss_o  = SW'(act_i) + SW'(off_i);
    se_o  = ss_o + SW'(wid_i);
    tot_o = SW'(act_i) + SW'(blank_i);
  end
endmodule

// File: rtl/nms_mode_derive.sv
module nms_mode_derive
  import nms_pkg::*;
(
  input  desc_t desc_i,
  output mode_t mode_o
);
  logic [FW-1:0] act [2];
  logic [FW-1:0] blk [2];
  logic [FW-1:0] off [2];
  logic [FW-1:0] wid [2];
  logic [SW-1:0] ss  [2];
  logic [SW-1:0] se  [2];
  logic [SW-1:0] tot [2];

  assign act[0] = desc_i.h_act;   assign act[1] = desc_i.v_act;
  assign blk[0] = desc_i.h_blank; assign blk[1] = desc_i.v_blank;
  assign off[0] = desc_i.h_off;   assign off[1] = desc_i.v_off;
  assign wid[0] = desc_i.h_wid;   assign wid[1] = desc_i.v_wid;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    nms_axis_derive #(.FW(FW), .SW(SW)) u_axis (
      .act_i(act[g]), .blank_i(blk[g]), .off_i(off[g]), .wid_i(wid[g]),
      .ss_o(ss[g]), .se_o(se[g]), .tot_o(tot[g])
    );
  end

  logic pol_en;
  assign pol_en = (desc_i.sync_type == SYNC_POL_VALID);

  always_comb begin
    // x10 as x8 + x2
    mode_o.pclk_x10 = (PCW'(desc_i.pclk) << 3) + (PCW'(desc_i.pclk) << 1);
    mode_o.h_act    = desc_i.h_act;
    mode_o.h_ss     = ss[0];
    mode_o.h_se     = se[0];
    mode_o.h_tot    = tot[0];
    mode_o.v_act    = desc_i.v_act;
    mode_o.v_ss     = ss[1];
    mode_o.v_se     = se[1];
    mode_o.v_tot    = tot[1];
    mode_o.hpos     = pol_en & desc_i.misc[0];
    mode_o.vpos     = pol_en & desc_i.misc[1];
    mode_o.il       = desc_i.interlace;
  end
endmodule

// File: rtl/nms_mode_keeper.sv
module nms_mode_keeper
  import nms_pkg::*;
#(
  parameter int unsigned MAX_DESC = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_start_i,
  input  logic  desc_valid_i,
  input  logic  pclk_nz_i,
  input  mode_t cand_i,
  output mode_t best_o
);
  localparam int unsigned CW = $clog2(MAX_DESC + 1);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_DESC);

  logic [CW-1:0] cnt_q, base_cnt;
  logic [FW-1:0] base_h;
  mode_t         best_q;
  logic          slot_ok, take;

  always_comb begin
    base_h   = frame_start_i ? '0 : best_q.h_act;
    base_cnt = frame_start_i ? '0 : cnt_q;
    slot_ok  = desc_valid_i && (base_cnt < MAX_C);
    take     = slot_ok && pclk_nz_i && (cand_i.h_act > base_h);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      best_q <= '0;
    end else begin
      if (frame_start_i) begin
        cnt_q  <= '0;
        best_q <= '0;
      end
      if (slot_ok) cnt_q  <= base_cnt + 1'b1;
      if (take)    best_q <= cand_i;
    end
  end

  assign best_o = best_q;

  assert_cnt_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C);
  assert_width_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> best_q.h_act >= $past(best_q.h_act));
  assert_zero_clk_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_i && !pclk_nz_i && !frame_start_i) |=> $stable(best_q));
endmodule

// File: rtl/nms_result_stage.sv
module nms_result_stage
  import nms_pkg::*;
#(
  parameter int unsigned MIN_H = 640,
  parameter int unsigned MIN_V = 480
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_end_i,
  input  logic  digital_i,
  input  mode_t best_i,
  output mode_t res_o,
  output logic  valid_o,
  output logic  digital_o
);
  logic  ok;
  mode_t res_q;
  logic  valid_q, dig_q;

  assign ok = (best_i.h_act >= FW'(MIN_H)) && (best_i.v_act >= FW'(MIN_V));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      dig_q   <= 1'b0;
    end else if (frame_end_i) begin
      res_q   <= ok ? best_i : '0;
      valid_q <= ok;
      dig_q   <= ok & digital_i;
    end
  end

  assign res_o     = res_q;
  assign valid_o   = valid_q;
  assign digital_o = dig_q;

  assert_valid_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (res_q.h_act >= FW'(MIN_H)) && (res_q.v_act >= FW'(MIN_V)));
  assert_hold_between_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable({res_q, valid_q, dig_q}));
  assert_digital_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> !dig_q);
  assert_sync_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (res_q.h_se >= res_q.h_ss) && (res_q.v_se >= res_q.v_ss));
endmodule

// File: rtl/native_mode_sel.sv
module native_mode_sel
  import nms_pkg::*;
#(
  parameter int unsigned MAX_DESC = 4,
  parameter int unsigned MIN_H    = 640,
  parameter int unsigned MIN_V    = 480
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           frame_start_i,
  input  logic           frame_end_i,
  input  logic           desc_valid_i,
  input  logic [15:0]    pclk_i,
  input  logic [11:0]    h_active_i,
  input  logic [11:0]    h_blank_i,
  input  logic [11:0]    h_sync_off_i,
  input  logic [11:0]    h_sync_width_i,
  input  logic [11:0]    v_active_i,
  input  logic [11:0]    v_blank_i,
  input  logic [11:0]    v_sync_off_i,
  input  logic [11:0]    v_sync_width_i,
  input  logic [1:0]     sync_type_i,
  input  logic [1:0]     misc_i,
  input  logic           interlace_i,
  input  logic           digital_i,
  output logic           valid_o,
  output logic [19:0]    pixel_clock_o,
  output logic [11:0]    h_active_o,
  output logic [13:0]    h_sync_start_o,
  output logic [13:0]    h_sync_end_o,
  output logic [13:0]    h_total_o,
  output logic [11:0]    v_active_o,
  output logic [13:0]    v_sync_start_o,
  output logic [13:0]    v_sync_end_o,
  output logic [13:0]    v_total_o,
  output logic           hsync_pos_o,
  output logic           vsync_pos_o,
  output logic           interlace_o,
  output logic           digital_o
);
  desc_t desc;
  mode_t cand, best, res;

  always_comb begin
    desc.pclk      = pclk_i;
    desc.h_act     = h_active_i;
    desc.h_blank   = h_blank_i;
    desc.h_off     = h_sync_off_i;
    desc.h_wid     = h_sync_width_i;
    desc.v_act     = v_active_i;
    desc.v_blank   = v_blank_i;
    desc.v_off     = v_sync_off_i;
    desc.v_wid     = v_sync_width_i;
    desc.sync_type = sync_type_i;
    desc.misc      = misc_i;
    desc.interlace = interlace_i;
  end

  nms_mode_derive u_derive (.desc_i(desc), .mode_o(cand));

  nms_mode_keeper #(.MAX_DESC(MAX_DESC)) u_keeper (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .desc_valid_i(desc_valid_i), .pclk_nz_i(|pclk_i),
    .cand_i(cand), .best_o(best)
  );

  nms_result_stage #(.MIN_H(MIN_H), .MIN_V(MIN_V)) u_result (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_end_i(frame_end_i),
    .digital_i(digital_i), .best_i(best), .res_o(res),
    .valid_o(valid_o), .digital_o(digital_o)
  );

  assign pixel_clock_o  = res.pclk_x10;
  assign h_active_o     = res.h_act;
  assign h_sync_start_o = res.h_ss;
  assign h_sync_end_o   = res.h_se;
  assign h_total_o      = res.h_tot;
  assign v_active_o     = res.v_act;
  assign v_sync_start_o = res.v_ss;
  assign v_sync_end_o   = res.v_se;
  assign v_total_o      = res.v_tot;
  assign hsync_pos_o    = res.hpos;
  assign vsync_pos_o    = res.vpos;
  assign interlace_o    = res.il;
endmodule

// File: tb/sim_native_mode_sel.sv
`timescale 1ns/1ps
module sim_native_mode_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 0, fe = 0, dv = 0, il = 0, dig = 0;
  logic [15:0] pclk = '0;
  logic [11:0] ha = '0, hb = '0, ho = '0, hw = '0, va = '0, vb = '0, vo = '0, vw = '0;
  logic [1:0]  st = '0, mi = '0;

  logic        valid, hpos, vpos, il_o, dig_o;
  logic [19:0] pc_o;
  logic [11:0] ha_o, va_o;
  logic [13:0] hss_o, hse_o, ht_o, vss_o, vse_o, vt_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  native_mode_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .frame_end_i(fe),
    .desc_valid_i(dv), .pclk_i(pclk),
    .h_active_i(ha), .h_blank_i(hb), .h_sync_off_i(ho), .h_sync_width_i(hw),
    .v_active_i(va), .v_blank_i(vb), .v_sync_off_i(vo), .v_sync_width_i(vw),
    .sync_type_i(st), .misc_i(mi), .interlace_i(il), .digital_i(dig),
    .valid_o(valid), .pixel_clock_o(pc_o),
    .h_active_o(ha_o), .h_sync_start_o(hss_o), .h_sync_end_o(hse_o), .h_total_o(ht_o),
    .v_active_o(va_o), .v_sync_start_o(vss_o), .v_sync_end_o(vse_o), .v_total_o(vt_o),
    .hsync_pos_o(hpos), .vsync_pos_o(vpos), .interlace_o(il_o), .digital_o(dig_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: held choice and latched result
  int m_cnt, m_h, m_v, m_pc, m_hss, m_hse, m_ht, m_vss, m_vse, m_vt, m_hp, m_vp, m_il;
  int e_valid, e_pc, e_h, e_hss, e_hse, e_ht, e_v, e_vss, e_vse, e_vt, e_hp, e_vp, e_il, e_dig;

  task automatic m_clear_store();
    m_h = 0; m_v = 0; m_pc = 0; m_hss = 0; m_hse = 0; m_ht = 0;
    m_vss = 0; m_vse = 0; m_vt = 0; m_hp = 0; m_vp = 0; m_il = 0;
  endtask

  initial begin
    m_cnt = 0; m_clear_store();
    e_valid = 0; e_pc = 0; e_h = 0; e_hss = 0; e_hse = 0; e_ht = 0; e_v = 0;
    e_vss = 0; e_vse = 0; e_vt = 0; e_hp = 0; e_vp = 0; e_il = 0; e_dig = 0;
  end

  always @(posedge clk) begin
    int base_h, base_c, ok;
    if (rst_n) begin
      if (fe) begin
        ok = (m_h >= 640 && m_v >= 480) ? 1 : 0;
        e_valid = ok;
        e_pc  = ok ? m_pc * 10 : 0;
        e_h   = ok ? m_h : 0;   e_hss = ok ? m_hss : 0; e_hse = ok ? m_hse : 0; e_ht = ok ? m_ht : 0;
        e_v   = ok ? m_v : 0;   e_vss = ok ? m_vss : 0; e_vse = ok ? m_vse : 0; e_vt = ok ? m_vt : 0;
        e_hp  = ok ? m_hp : 0;  e_vp = ok ? m_vp : 0;   e_il = ok ? m_il : 0;
        e_dig = ok & int'(dig);
      end
      base_h = fs ? 0 : m_h;
      base_c = fs ? 0 : m_cnt;
      if (fs) begin m_cnt = 0; m_clear_store(); end
      if (dv && base_c < 4) begin
        m_cnt = base_c + 1;
        if (pclk != 0 && int'(ha) > base_h) begin
          m_h = ha; m_v = va; m_pc = pclk;
          m_hss = ha + ho; m_hse = ha + ho + hw; m_ht = ha + hb;
          m_vss = va + vo; m_vse = va + vo + vw; m_vt = va + vb;
          m_hp = (st == 2'd3) ? int'(mi[0]) : 0;
          m_vp = (st == 2'd3) ? int'(mi[1]) : 0;
          m_il = il;
        end
      end
    end
  end

  // R10: every cycle the ports must match the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 model valid", valid, e_valid);
      chk("R10 model pclk", pc_o, e_pc);
      chk("R10 model h_active", ha_o, e_h);
      chk("R10 model h_sync_start", hss_o, e_hss);
      chk("R10 model h_sync_end", hse_o, e_hse);
      chk("R10 model h_total", ht_o, e_ht);
      chk("R10 model v_active", va_o, e_v);
      chk("R10 model v_sync_start", vss_o, e_vss);
      chk("R10 model v_sync_end", vse_o, e_vse);
      chk("R10 model v_total", vt_o, e_vt);
      chk("R10 model flags", {hpos, vpos, il_o}, {e_hp[0], e_vp[0], e_il[0]});
      chk("R10 model digital", dig_o, e_dig);
    end
  end

  task automatic send(input int p, input int a_h, input int b_h, input int o_h, input int w_h,
                      input int a_v, input int b_v, input int o_v, input int w_v,
                      input int s, input int m, input int i);
    @(negedge clk);
    dv = 1; pclk = 16'(p);
    ha = 12'(a_h); hb = 12'(b_h); ho = 12'(o_h); hw = 12'(w_h);
    va = 12'(a_v); vb = 12'(b_v); vo = 12'(o_v); vw = 12'(w_v);
    st = 2'(s); mi = 2'(m); il = i[0];
    @(negedge clk);
    dv = 0;
  endtask

  task automatic start_frame();
    @(negedge clk); fs = 1;
    @(negedge clk); fs = 0;
  endtask

  task automatic end_frame(input bit d);
    @(negedge clk); fe = 1; dig = d;
    @(negedge clk); fe = 0; dig = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", valid, 0);
    chk("R1 reset pclk", pc_o, 0);
    chk("R1 reset h_total", ht_o, 0);
    chk("R1 reset digital", dig_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // A: rising, falling, zero-clock widest, then widest valid
    start_frame();
    send(6500, 1024, 320, 24, 136, 768, 38, 3, 6, 0, 0, 0);
    send(4000, 800, 256, 40, 128, 600, 28, 1, 4, 0, 0, 0);
    send(0, 1920, 280, 88, 44, 1080, 45, 4, 5, 3, 3, 1);
    send(10800, 1280, 408, 48, 112, 1024, 42, 1, 3, 3, 1, 0);
    end_frame(0);
    chk("R2 zero clock skipped h_active", ha_o, 1280);
    chk("R4 h_sync_start", hss_o, 1328);
    chk("R4 h_sync_end", hse_o, 1440);
    chk("R4 h_total", ht_o, 1688);
    chk("R4 v_sync_start", vss_o, 1025);
    chk("R4 v_sync_end", vse_o, 1028);
    chk("R4 v_total", vt_o, 1066);
    chk("R5 pixel clock x10", pc_o, 108000);
    chk("R6 hpos with type 3", hpos, 1);
    chk("R6 vpos with type 3", vpos, 0);
    chk("R8 digital low passed", dig_o, 0);

    // B: equal width keeps first; type 2 blocks polarity
    start_frame();
    send(7425, 1280, 370, 110, 40, 720, 30, 5, 5, 2, 3, 1);
    send(10800, 1280, 408, 48, 112, 1024, 42, 1, 3, 3, 3, 0);
    end_frame(1);
    chk("R3 equal width keeps first v_active", va_o, 720);
    chk("R6 no polarity unless type 3", {hpos, vpos}, 0);
    chk("R6 interlace copied", il_o, 1);
    chk("R8 digital passed when valid", dig_o, 1);
    repeat (5) @(negedge clk);
    chk("R10 held after idle", va_o, 720);

    // C: too narrow
    start_frame();
    send(2500, 600, 200, 16, 96, 480, 45, 10, 2, 3, 3, 1);
    end_frame(1);
    chk("R7 narrow invalid", valid, 0);
    chk("R7 invalid zeroes timing", ht_o, 0);
    chk("R7 invalid zeroes flags", {hpos, vpos, il_o}, 0);
    chk("R8 digital blocked when invalid", dig_o, 0);

    // D: one line short
    start_frame();
    send(2517, 640, 160, 16, 96, 479, 45, 10, 2, 0, 0, 0);
    end_frame(0);
    chk("R7 479 lines invalid", valid, 0);

    // E: exactly at floor
    start_frame();
    send(2517, 640, 160, 16, 96, 480, 45, 10, 2, 0, 0, 0);
    end_frame(1);
    chk("R7 640x480 valid", valid, 1);
    chk("R4 640 total", ht_o, 800);
    chk("R4 480 total", vt_o, 525);
    chk("R5 25170 kHz", pc_o, 25170);

    // F: empty frame after a valid one
    start_frame();
    end_frame(1);
    chk("R9 empty frame invalid", valid, 0);

    // G: five strobes, first zero-clock, fifth widest
    start_frame();
    send(0, 1920, 280, 88, 44, 1080, 45, 4, 5, 0, 0, 0);
    send(4000, 800, 256, 40, 128, 600, 28, 1, 4, 0, 0, 0);
    chk("R10 no change mid-frame", valid, 0);
    send(6500, 1024, 320, 24, 136, 768, 38, 3, 6, 0, 0, 0);
    send(2517, 640, 160, 16, 96, 480, 45, 10, 2, 0, 0, 0);
    send(16200, 1600, 560, 64, 192, 1200, 50, 1, 3, 3, 3, 0);
    end_frame(0);
    chk("R11 fifth strobe ignored", ha_o, 1024);

    // H: smaller mode in a fresh frame
    start_frame();
    send(4000, 800, 256, 40, 128, 600, 28, 1, 4, 0, 0, 0);
    end_frame(0);
    chk("R9 fresh frame picks 800", ha_o, 800);

    // I: descriptor in the same cycle as start counts for new frame
    @(negedge clk);
    fs = 1; dv = 1; pclk = 16'd6500; ha = 12'd1024; hb = 12'd320; ho = 12'd24; hw = 12'd136;
    va = 12'd768; vb = 12'd38; vo = 12'd3; vw = 12'd6; st = 2'd0; mi = 2'd0; il = 0;
    @(negedge clk);
    fs = 0; dv = 0;
    end_frame(0);
    chk("R9 same-cycle descriptor kept", ha_o, 1024);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule